// File: doc/BRIEF.md
# Sign-Error Adaptive Mains Interference Canceller

This block is the digital core of an adaptive canceller for periodic mains hum. Two kinds of 8-bit unsigned samples reach it over one shared input: samples of a line-frequency reference, and samples of the cleaned signal that comes back from the analog summing point. A channel tag marks each sample's kind. The block keeps the most recent reference samples in a ring. Each time a reference sample arrives, it forms an antinoise value as the sum of each weight times the reference sample of matching age. The external circuit adds that antinoise to the contaminated signal.

Each error sample adapts the weights with a multiplier-free sign-error rule. Only the side of mid-scale on which the error sample lies is used. The whole reference sample of matching age is then added to, or subtracted from, the raw 16:16 weight word. Because the sample lands in the fractional field, the step size is small and no multiplier is needed. In normal use the two channels are sampled in turn, at a reference rate near eight samples per mains cycle, which puts consecutive reference samples about 45 degrees apart.

Top module: `lms_canceller`

## Requirements
- R1: After reset all weights and ring entries are zero, anti_valid is 0 and anti_data is 128. The first antinoise value after reset is therefore 128.
- R2: A reference sample is a cycle with smp_valid=1 and smp_chan=0. It is captured at a rising edge. anti_valid then goes high for exactly one cycle, starting at the next rising edge, and anti_data carries the new value in that cycle.
- R3: The antinoise is the sum over k=0..7 of W[k]×R[k], where R[k] is the k-th newest reference sample (R[0] is the one just captured) and W[k] is a signed 32-bit word with 16 fractional bits. The output is that sum shifted right by 16 with rounding toward minus infinity, plus 128. A ninth reference sample displaces the oldest one.
- R4: An error sample is a cycle with smp_valid=1 and smp_chan=1. If its value is 128 or more, the reference sample of matching age R[k] is added to the raw word of each W[k]. If its value is 127 or less, R[k] is subtracted.
- R5: An error sample produces no anti_valid pulse and leaves the reference ring unchanged.
- R6: Weight words saturate at the signed limits of their width and never wrap.
- R7: The output is clamped to 0 when the scaled value plus 128 is below 0, and to 255 when it is above 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A sample is presented this cycle |
| smp_chan | input | 1 | Channel tag: 0 = reference, 1 = error |
| smp_data | input | 8 | Unsigned sample value, mid-scale 128 |
| anti_valid | output | 1 | One-cycle strobe for a new antinoise value |
| anti_data | output | 8 | Unsigned antinoise value, mid-scale 128 |

## Verification
The assertions take for granted that smp_chan and smp_data are known whenever smp_valid is high. They also assume the ring size is a power of two, so that the read pointer wraps naturally. The bench drives every input at the falling edge, so each sample is fully defined when it is captured, and it keeps smp_valid low between samples. Saturation cannot be reached with 16 fractional bits in a short run. The bench therefore feeds the same stimulus to a second instance with narrow weight words, where a few hundred error samples push the weights to both limits.

// File: rtl/lms_pkg.sv
package lms_pkg;
    typedef enum logic {
        CH_REF = 1'b0,
        CH_ERR = 1'b1
    } chan_e;
endpackage

// File: rtl/lms_ref_ring.sv
module lms_ref_ring #(
    parameter int TAPS  = 8,
    parameter int SMP_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [SMP_W-1:0]            wr_data,
    output logic [TAPS-1:0][SMP_W-1:0]  taps
);
    localparam int PTR_W = $clog2(TAPS);

    typedef struct packed {
        logic [PTR_W-1:0]            ptr;
        logic [TAPS-1:0][SMP_W-1:0]  slot;
    } ring_t;

    ring_t ring_d, ring_q;

    always_comb begin
        ring_d = ring_q;
        if (wr_en) begin
            ring_d.slot[ring_q.ptr] = wr_data;
            ring_d.ptr              = ring_q.ptr + PTR_W'(1);
        end
    end

    // age-ordered view: index 0 is the newest sample
    always_comb begin
        for (int k = 0; k < TAPS; k++) begin
            taps[k] = ring_q.slot[ring_q.ptr - PTR_W'(k + 1)];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ring_d;
    end

    // R3
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ring_q.ptr == $past(ring_q.ptr) + PTR_W'(1));

    // R5
    ring_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ring_q));
endmodule

// File: rtl/lms_weight_bank.sv
module lms_weight_bank #(
    parameter int TAPS   = 8,
    parameter int SMP_W  = 8,
    parameter int INT_W  = 16,
    parameter int FRAC_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            upd_en,
    input  logic                            err_pos,
    input  logic [TAPS-1:0][SMP_W-1:0]      taps,
    output logic [TAPS-1:0][INT_W+FRAC_W-1:0] wts
);
    localparam int W_W = INT_W + FRAC_W;
    localparam int XW  = W_W + SMP_W + 1;
    localparam logic signed [XW-1:0] W_MAX = XW'((64'sd1 <<< (W_W - 1)) - 64'sd1);
    localparam logic signed [XW-1:0] W_MIN = XW'(-(64'sd1 <<< (W_W - 1)));

    typedef struct packed {
        logic [TAPS-1:0][W_W-1:0] w;
    } wbank_t;

    wbank_t wt_d, wt_q;

    always_comb begin
        logic signed [XW-1:0] cur;
        logic signed [XW-1:0] stp;
        logic signed [XW-1:0] nxt;
        wt_d = wt_q;
        cur  = '0;
        stp  = '0;
        nxt  = '0;
        if (upd_en) begin
            for (int k = 0; k < TAPS; k++) begin
                cur = XW'(signed'(wt_q.w[k]));
                stp = XW'(signed'({1'b0, taps[k]}));
                nxt = err_pos ? cur + stp : cur - stp;
                if (nxt > W_MAX)      wt_d.w[k] = W_MAX[W_W-1:0];
                else if (nxt < W_MIN) wt_d.w[k] = W_MIN[W_W-1:0];
                else                  wt_d.w[k] = nxt[W_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wt_q <= '0;
        else        wt_q <= wt_d;
    end

    assign wts = wt_q.w;

    for (genvar k = 0; k < TAPS; k++) begin : g_chk
        // R4
        weight_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_en && err_pos) |=> $signed(wt_q.w[k]) >= $past($signed(wt_q.w[k])));
        // R4
        weight_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_en && !err_pos) |=> $signed(wt_q.w[k]) <= $past($signed(wt_q.w[k])));
        // R6
        no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_en && err_pos && !wt_q.w[k][W_W-1]) |=> !wt_q.w[k][W_W-1]);
        // R6
        no_wrap_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (upd_en && !err_pos && wt_q.w[k][W_W-1]) |=> wt_q.w[k][W_W-1]);
        // R1
        hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !upd_en |=> $stable(wt_q.w[k]));
    end
endmodule

// File: rtl/lms_dot_out.sv
module lms_dot_out #(
    parameter int TAPS   = 8,
    parameter int SMP_W  = 8,
    parameter int INT_W  = 16,
    parameter int FRAC_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              go,
    input  logic [TAPS-1:0][SMP_W-1:0]        taps,
    input  logic [TAPS-1:0][INT_W+FRAC_W-1:0] wts,
    output logic                              out_valid,
    output logic [SMP_W-1:0]                  out_data
);
    localparam int W_W   = INT_W + FRAC_W;
    localparam int SUM_W = W_W + SMP_W + 1 + $clog2(TAPS);
    localparam int MID   = 1 << (SMP_W - 1);
    localparam logic signed [SUM_W-1:0] LO_L = SUM_W'(-MID);
    localparam logic signed [SUM_W-1:0] HI_L = SUM_W'(MID - 1);

    typedef struct packed {
        logic             pend;
        logic             vld;
        logic [SMP_W-1:0] data;
    } out_t;

    out_t o_d, o_q;
    logic signed [SUM_W-1:0] acc;
    logic signed [SUM_W-1:0] ip;

    always_comb begin
        acc = '0;
        for (int k = 0; k < TAPS; k++) begin
            acc = acc + SUM_W'(signed'(wts[k])) * SUM_W'(signed'({1'b0, taps[k]}));
        end
        ip = acc >>> FRAC_W;
    end

    always_comb begin
        o_d      = o_q;
        o_d.pend = go;
        o_d.vld  = o_q.pend;
        if (o_q.pend) begin
            if (ip < LO_L)      o_d.data = '0;
            else if (ip > HI_L) o_d.data = '1;
            else                o_d.data = SMP_W'(ip + SUM_W'(MID));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '{pend: 1'b0, vld: 1'b0, data: SMP_W'(MID)};
        else        o_q <= o_d;
    end

    assign out_valid = o_q.vld;
    assign out_data  = o_q.data;

    // R2
    out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_q.vld |-> $past(go, 2));

    // R2
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !o_q.pend |=> $stable(o_q.data));
endmodule

// File: rtl/lms_canceller.sv
module lms_canceller #(
    parameter int TAPS   = 8,
    parameter int SMP_W  = 8,
    parameter int INT_W  = 16,
    parameter int FRAC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic             smp_chan,
    input  logic [SMP_W-1:0] smp_data,
    output logic             anti_valid,
    output logic [SMP_W-1:0] anti_data
);
    import lms_pkg::*;

    localparam int W_W = INT_W + FRAC_W;
    localparam logic [SMP_W-1:0] MID = SMP_W'(1 << (SMP_W - 1));

    logic                           ref_stb;
    logic                           err_stb;
    logic                           err_pos;
    logic [TAPS-1:0][SMP_W-1:0]     taps;
    logic [TAPS-1:0][W_W-1:0]       wts;

    assign ref_stb = smp_valid && (chan_e'(smp_chan) == CH_REF);
    assign err_stb = smp_valid && (chan_e'(smp_chan) == CH_ERR);
    assign err_pos = smp_data >= MID;

    lms_ref_ring #(.TAPS(TAPS), .SMP_W(SMP_W)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ref_stb),
        .wr_data (smp_data),
        .taps    (taps)
    );

    lms_weight_bank #(.TAPS(TAPS), .SMP_W(SMP_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_wts (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (err_stb),
        .err_pos (err_pos),
        .taps    (taps),
        .wts     (wts)
    );

    lms_dot_out #(.TAPS(TAPS), .SMP_W(SMP_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (ref_stb),
        .taps      (taps),
        .wts       (wts),
        .out_valid (anti_valid),
        .out_data  (anti_data)
    );

    // R5
    err_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_stb |=> ##1 !anti_valid);
endmodule

// File: tb/lms_canceller_test.sv
module lms_canceller_test;
    localparam int CLK_P = 10;
    localparam int NV    = 24;
    // {channel, value}: channel 0 = reference, 1 = error
    localparam logic [8:0] VEC [NV] = '{
        {1'b0, 8'd128}, {1'b0, 8'd199}, {1'b0, 8'd228}, {1'b0, 8'd199},
        {1'b0, 8'd128}, {1'b0, 8'd57},  {1'b0, 8'd28},  {1'b0, 8'd57},
        {1'b1, 8'd200}, {1'b0, 8'd128}, {1'b1, 8'd40},  {1'b0, 8'd199},
        {1'b1, 8'd128}, {1'b0, 8'd228}, {1'b1, 8'd127}, {1'b0, 8'd199},
        {1'b1, 8'd255}, {1'b0, 8'd128}, {1'b1, 8'd0},   {1'b0, 8'd57},
        {1'b1, 8'd180}, {1'b0, 8'd28},  {1'b1, 8'd90},  {1'b0, 8'd57}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_valid = 1'b0;
    logic       smp_chan = 1'b0;
    logic [7:0] smp_data = 8'd0;
    logic       anti_valid, small_valid;
    logic [7:0] anti_data, small_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    longint mw [8];
    int     hist [8];

    always #(CLK_P / 2) clk = ~clk;

    lms_canceller uut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
        .smp_data(smp_data), .anti_valid(anti_valid), .anti_data(anti_data)
    );

    lms_canceller #(.INT_W(4), .FRAC_W(4)) uut_small (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
        .smp_data(smp_data), .anti_valid(small_valid), .anti_data(small_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_out();
        longint acc = 0;
        longint ip;
        for (int k = 0; k < 8; k++) acc += mw[k] * longint'(hist[k]);
        ip = acc >>> 16;
        if (ip + 128 < 0)   return 0;
        if (ip + 128 > 255) return 255;
        return int'(ip + 128);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            mw[k] = 0;
            hist[k] = 0;
        end
    endtask

    task automatic drive(input logic ch, input logic [7:0] d);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_chan  = ch;
        smp_data  = d;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic ref_in(input logic [7:0] d);
        drive(1'b0, d);
        for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = int'(d);
    endtask

    task automatic ref_chk(input logic [7:0] d, input string req);
        int e;
        ref_in(d);
        e = model_out();
        @(negedge clk);
        chk(anti_valid === 1'b1, "R2 strobe", int'(anti_valid), 1);
        chk(anti_data == 8'(e), req, int'(anti_data), e);
        @(negedge clk);
        chk(anti_valid === 1'b0, "R2 single pulse", int'(anti_valid), 0);
    endtask

    task automatic err_in(input logic [7:0] d, input bit check);
        longint v;
        drive(1'b1, d);
        for (int k = 0; k < 8; k++) begin
            v = (d >= 8'd128) ? mw[k] + hist[k] : mw[k] - hist[k];
            if (v > 64'sd2147483647)  v = 64'sd2147483647;
            if (v < -64'sd2147483648) v = -64'sd2147483648;
            mw[k] = v;
        end
        if (check) begin
            @(negedge clk);
            chk(anti_valid === 1'b0, "R5 no strobe", int'(anti_valid), 0);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1
        chk(anti_valid === 1'b0, "R1 valid", int'(anti_valid), 0);
        chk(anti_data == 8'd128, "R1 data", int'(anti_data), 128);

        // R3 R5: table walk; first entry shows R1 zero weights
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][8]) err_in(VEC[i][7:0], 1'b1);
            else           ref_chk(VEC[i][7:0], "R3 table");
        end

        // R4: value 128 counts as positive
        do_reset();
        for (int i = 0; i < 8; i++) ref_in(8'd255);
        err_in(8'd128, 1'b0);
        ref_chk(8'd255, "R4 at 128");
        chk(anti_data == 8'd135, "R4 positive step", int'(anti_data), 135);

        // R4: value 127 counts as negative; floor of negative sum
        do_reset();
        for (int i = 0; i < 8; i++) ref_in(8'd255);
        err_in(8'd127, 1'b0);
        ref_chk(8'd255, "R4 at 127");
        chk(anti_data == 8'd120, "R4 negative step floor", int'(anti_data), 120);

        // R5: error sample leaves ring; next ref uses unchanged history
        err_in(8'd50, 1'b1);
        ref_chk(8'd10, "R5 ring kept");

        // R7: clamp high then low
        do_reset();
        for (int i = 0; i < 8; i++) ref_in(8'd255);
        for (int i = 0; i < 20; i++) err_in(8'd200, 1'b0);
        ref_chk(8'd255, "R7 clamp high");
        chk(anti_data == 8'd255, "R7 high value", int'(anti_data), 255);
        for (int i = 0; i < 45; i++) err_in(8'd3, 1'b0);
        ref_chk(8'd255, "R7 clamp low");
        chk(anti_data == 8'd0, "R7 low value", int'(anti_data), 0);

        // R6: narrow weights saturate at +127 / -128 raw
        do_reset();
        for (int i = 0; i < 8; i++) ref_in(8'd1);
        for (int i = 0; i < 200; i++) err_in(8'd255, 1'b0);
        ref_in(8'd1);
        @(negedge clk);
        chk(small_valid === 1'b1, "R6 strobe", int'(small_valid), 1);
        chk(small_data == 8'd191, "R6 upper limit", int'(small_data), 191);
        for (int i = 0; i < 400; i++) err_in(8'd0, 1'b0);
        ref_in(8'd1);
        @(negedge clk);
        chk(small_data == 8'd64, "R6 lower limit", int'(small_data), 64);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule